// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B, and moves data from one to the other in either direction. Each direction has its own storage register, and each register has its own capture clock. The A-side register samples the A bus on a rising edge of the A-capture clock. The B-side register samples the B bus on a rising edge of the B-capture clock.

For each direction a select input chooses what is passed across: either the live value on the opposite bus, with no register in the way, or the value held in that direction's register. One active-low enable and one direction input decide which bus, if any, the block drives. While the enable is inactive the block is isolated and drives neither bus. Both registers keep capturing in isolation, and they can capture at the same time.

Each bus is brought out as three ports: an input, an output and an output-enable. Whatever sits above the block resolves the shared wire from these. A synthesis-time parameter turns every transfer into an inverting one, for live and stored data alike.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge on `cap_a_clk` loads `a_in` into the A-side register. The register keeps that value until the next such edge or a reset, whatever the other inputs do.
- R2: A rising edge on `cap_b_clk` loads `b_in` into the B-side register. The register keeps that value until the next such edge or a reset, whatever the other inputs do.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 (isolation).
- R4: While `oe_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0. `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: `b_out` carries the live `a_in` when `sel_a_stored` is 0 and the A-side register when it is 1. The live path has no register in it, so `b_out` follows `a_in` in the same cycle.
- R7: `a_out` carries the live `b_in` when `sel_b_stored` is 0 and the B-side register when it is 1. The live path has no register in it.
- R8: Both registers capture whether the outputs are enabled or not, including in isolation. Both can capture on the same edge.
- R9: When `rst_n` is 0, both registers clear to zero at once, without waiting for a clock edge.
- R10: With `INVERT` = 0, data is transferred unchanged. With `INVERT` = 1, every bit of `a_out` and `b_out` is the complement of the selected live or stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_a_clk | input | 1 | Capture clock for the A-side register (rising edge) |
| cap_b_clk | input | 1 | Capture clock for the B-side register (rising edge) |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_a2b | input | 1 | 1: drive B from the A path; 0: drive A from the B path |
| sel_a_stored | input | 1 | B-bus source: 0 live A input, 1 A-side register |
| sel_b_stored | input | 1 | A-bus source: 0 live B input, 1 B-side register |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value offered to the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value offered to the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The bench loads both registers while the block is isolated and reads them back only after it enables an output. A design that gated capture with the enable would show the reset value there instead of the stored data. The bench also pulses one capture clock while the other direction is showing its stored value, and it changes the live inputs without any clock pulse. Any crosstalk between the two registers, or a live path with a hidden register in it, shows up as stale or wrong data in the very cycle the input changes. Finally, the bench resets in the middle of a run with stored data selected, and it runs a second, inverting instance alongside the first. A reset that waited for a clock edge, or an inversion applied only to live data, gives the wrong value on one of the two instances.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;

  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int unsigned W = xcvr_pkg::XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1 R2 R8
  capture_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
  parameter int unsigned W      = xcvr_pkg::XCVR_W,
  parameter bit          INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         use_stored,
  output logic [W-1:0] y
);
  logic [W-1:0] picked;

  always_comb picked = use_stored ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign y = ~picked;
    end else begin : g_true
      assign y = picked;
    end
  endgenerate
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl (
  input  logic oe_n,
  input  logic dir_a2b,
  output logic a_oe,
  output logic b_oe
);
  import xcvr_pkg::*;

  xfer_dir_e dir_s;

  always_comb begin
    dir_s = xfer_dir_e'(dir_a2b);
    a_oe  = 1'b0;
    b_oe  = 1'b0;
    if (!oe_n) begin
      if (dir_s == DIR_TO_B) b_oe = 1'b1;
      else                   a_oe = 1'b1;
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int unsigned WIDTH  = xcvr_pkg::XCVR_W,
  parameter bit          INVERT = 1'b0
) (
  input  logic             cap_a_clk,
  input  logic             cap_b_clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir_a2b,
  input  logic             sel_a_stored,
  input  logic             sel_b_stored,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] a_side_q;
  logic [WIDTH-1:0] b_side_q;

  xcvr_hold_reg #(.W(WIDTH)) u_a_hold (
    .clk(cap_a_clk), .rst_n(rst_n), .d(a_in), .q(a_side_q)
  );

  xcvr_hold_reg #(.W(WIDTH)) u_b_hold (
    .clk(cap_b_clk), .rst_n(rst_n), .d(b_in), .q(b_side_q)
  );

  xcvr_path_sel #(.W(WIDTH), .INVERT(INVERT)) u_to_b (
    .live(a_in), .stored(a_side_q), .use_stored(sel_a_stored), .y(b_out)
  );

  xcvr_path_sel #(.W(WIDTH), .INVERT(INVERT)) u_to_a (
    .live(b_in), .stored(b_side_q), .use_stored(sel_b_stored), .y(a_out)
  );

  xcvr_drive_ctrl u_drive (
    .oe_n(oe_n), .dir_a2b(dir_a2b), .a_oe(a_oe), .b_oe(b_oe)
  );

  // R5
  no_dual_drive_chk: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  // R3
  isolate_chk: assert property (@(posedge cap_b_clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  // R4
  dir_pick_chk: assert property (@(posedge cap_a_clk) disable iff (!rst_n)
    !oe_n |-> (b_oe == dir_a2b) && (a_oe == !dir_a2b));

  // R6
  stored_to_b_chk: assert property (@(posedge cap_b_clk) disable iff (!rst_n)
    sel_a_stored && $stable(a_side_q) |-> $stable(b_out));
endmodule

// File: tb/regbus_xcvr_tb_top.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic cap_a_clk = 0, cap_b_clk = 0, rst_n = 0, oe_n = 1, dir_a2b = 0;
  logic sel_a_stored = 1, sel_b_stored = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, a_out_i, b_out_i;
  logic a_oe, b_oe, a_oe_i, b_oe_i;

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .rst_n(rst_n), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .rst_n(rst_n), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
    .a_in(a_in), .a_out(a_out_i), .a_oe(a_oe_i), .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R9";
  logic [W-1:0] m_a = '0, m_b = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) t=%0t act=%0h exp=%0h", req, phase, $time, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(posedge clk) begin
    if (!done) begin
      logic [W-1:0] eb, ea;
      logic exp_aoe, exp_boe;
      eb = sel_a_stored ? m_a : a_in;
      ea = sel_b_stored ? m_b : b_in;
      exp_aoe = !oe_n && !dir_a2b;
      exp_boe = !oe_n && dir_a2b;
      chk(a_oe == exp_aoe && b_oe == exp_boe, oe_n ? "R3" : "R4",
          {a_oe, b_oe}, {exp_aoe, exp_boe});
      chk(!(a_oe && b_oe) && !(a_oe_i && b_oe_i), "R5", {a_oe, b_oe}, 0);
      chk(b_out == eb, "R6", b_out, eb);
      chk(a_out == ea, "R7", a_out, ea);
      chk(b_out_i == ~eb && a_out_i == ~ea, "R10",
          {b_out_i, a_out_i}, {~eb, ~ea});
    end
  end

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic oen, input logic dir,
                      input logic sa, input logic sb,
                      input bit pa, input bit pb);
    @(negedge clk);
    cap_a_clk = 0; cap_b_clk = 0;
    a_in = a; b_in = b; oe_n = oen; dir_a2b = dir;
    sel_a_stored = sa; sel_b_stored = sb;
    #1;
    if (pa) begin cap_a_clk = 1; if (rst_n) m_a = a; end
    if (pb) begin cap_b_clk = 1; if (rst_n) m_b = b; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state, stored paths selected, capture edges ignored
    phase = "R9";
    step(8'hC3, 8'h96, 1, 0, 1, 1, 1, 1);
    step(8'hC3, 8'h96, 0, 1, 1, 1, 0, 0);
    @(negedge clk); rst_n = 1;
    // R8: store both in isolation on the same edge
    phase = "R8";
    step(8'hA5, 8'h3C, 1, 1, 1, 1, 1, 1);
    step(8'h00, 8'h00, 1, 0, 1, 1, 0, 0);
    // R1 / R6: drive B from stored A, then live A
    phase = "R1";
    step(8'h11, 8'h22, 0, 1, 1, 1, 0, 0);
    phase = "R6";
    step(8'h11, 8'h22, 0, 1, 0, 1, 0, 0);
    step(8'hFE, 8'h22, 0, 1, 0, 1, 0, 0);
    step(8'h00, 8'hFF, 0, 1, 0, 0, 0, 0);
    // R2 / R7: drive A from stored B, then live B
    phase = "R2";
    step(8'h44, 8'h55, 0, 0, 1, 1, 0, 0);
    phase = "R7";
    step(8'h44, 8'h81, 0, 0, 1, 0, 0, 0);
    step(8'h44, 8'h7E, 0, 0, 1, 0, 0, 0);
    // R1: A capture alone leaves the B register untouched
    phase = "R1";
    step(8'h5A, 8'hEE, 0, 0, 1, 1, 1, 0);
    step(8'h00, 8'h00, 0, 1, 1, 1, 0, 0);
    // R2: B capture alone while outputs disabled
    phase = "R2";
    step(8'h77, 8'h9C, 1, 0, 1, 1, 0, 1);
    step(8'h00, 8'h01, 0, 0, 1, 1, 0, 0);
    // boundary values through both registers
    phase = "R8";
    step(8'hFF, 8'h00, 0, 1, 1, 1, 1, 1);
    step(8'h0F, 8'hF0, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 16; i++)
      step(W'(i * 37), W'(i * 91), i[0], i[1], i[2], i[3], i[0] ^ i[2], i[1]);
    // R9: reset mid-run clears both registers immediately
    phase = "R9";
    @(negedge clk); sel_a_stored = 1; sel_b_stored = 1;
    #1 rst_n = 0; m_a = '0; m_b = '0;
    step(8'h12, 8'h34, 0, 1, 1, 1, 0, 0);
    @(negedge clk); rst_n = 1;
    step(8'h12, 8'h34, 0, 0, 1, 1, 0, 0);
    @(negedge clk); cap_a_clk = 0; cap_b_clk = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule